// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a 16-bit sticky record of why the chip last came out of reset or last entered a low-power mode. Single-cycle strobes from the reset controller, the watchdog and the power-mode sequencer each set a flag. The flag then holds until one of its own clearing events arrives or until software rewrites it. Software reads the whole word on a read port. Through a write port it can set or clear any implemented flag. A software write only changes stored bits and has no other effect.

The power-on event is the asynchronous reset of the register. Only the power-on and brown-out flags survive it, and they survive it set. Every other event is a synchronous strobe sampled on the rising clock edge. When a set and a clear for the same bit arrive in one cycle, the set wins. Any hardware event on a bit wins over a software write to that bit in the same cycle.

Top module: `rcause_reg`

## Requirements
- R1: While `por_n` is low, and on the first cycle after it is released, `rd_data` reads 0x0003: power-on flag (bit 0) and brown-out flag (bit 1) set, all other bits clear. This also clears the configuration-mismatch flag.
- R2: A one-cycle strobe sets its flag on the next rising edge. The mapping is: trap conflict to bit 15, bad access to bit 14, configuration mismatch to bit 9, external pin to bit 7, software reset to bit 6, watchdog expiry to bit 4, sleep entry to bit 3, idle entry to bit 2, brown-out to bit 1.
- R3: With no strobe and no write, every flag keeps its value.
- R4: A brown-out strobe sets bit 1. It clears bits 15, 14, 7, 6, 4, 3 and 2, and leaves bits 9 and 0 unchanged.
- R5: The watchdog flag (bit 4) is cleared by a sleep-entry strobe, an idle-entry strobe or a watchdog-clear strobe.
- R6: When a set and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R7: A write with `wr_en` high loads the implemented bits (mask 0xC2DF) from `wr_data` on the next edge. No bit is touched that the write does not name.
- R8: A hardware set or clear of a bit overrides a write to that same bit in the same cycle. The other bits still take the written value.
- R9: Bits 13 to 10, 8 and 5 always read 0, whatever is written to them.
- R10: The configuration-mismatch flag (bit 9) is cleared only by power-on or by software. Brown-out, power-save and watchdog-clear strobes leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on event, active low, asynchronous |
| ev_brownout | input | 1 | Brown-out strobe |
| ev_ext_pin | input | 1 | External reset pin strobe |
| ev_sw_reset | input | 1 | Software reset instruction strobe |
| ev_wdt_expire | input | 1 | Watchdog timeout strobe |
| ev_trap_conflict | input | 1 | Trap conflict strobe |
| ev_bad_access | input | 1 | Illegal opcode or uninitialized register access strobe |
| ev_cfg_mismatch | input | 1 | Configuration mismatch strobe |
| ev_enter_sleep | input | 1 | Sleep-mode power-save instruction strobe |
| ev_enter_idle | input | 1 | Idle-mode power-save instruction strobe |
| ev_wdt_clear | input | 1 | Watchdog clear instruction strobe |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write data |
| rd_data | output | 16 | Current status word |

## Verification
Every strobe and every write is visible on `rd_data` exactly one rising edge after the edge that samples it. The power-on input acts at once, without waiting for a clock edge. The bench drives all inputs on a falling edge and holds them for one full cycle. It then reads `rd_data` on the next falling edge, which comes half a period after the edge that loaded the result. For the asynchronous power-on case, it reads the output a moment after `por_n` falls, with no clock edge in between.

// File: rtl/rcause_pkg.sv
package rcause_pkg;

    localparam int RC_W = 16;

    // Flag positions; software decodes these
    localparam int POS_TRAP   = 15;
    localparam int POS_BADACC = 14;
    localparam int POS_CFG    = 9;
    localparam int POS_EXT    = 7;
    localparam int POS_SWRST  = 6;
    localparam int POS_WDT    = 4;
    localparam int POS_SLEEP  = 3;
    localparam int POS_IDLE   = 2;
    localparam int POS_BOR    = 1;
    localparam int POS_POR    = 0;

    localparam logic [RC_W-1:0] IMPL_MASK =
        (RC_W'(1) << POS_TRAP)  | (RC_W'(1) << POS_BADACC) |
        (RC_W'(1) << POS_CFG)   | (RC_W'(1) << POS_EXT)    |
        (RC_W'(1) << POS_SWRST) | (RC_W'(1) << POS_WDT)    |
        (RC_W'(1) << POS_SLEEP) | (RC_W'(1) << POS_IDLE)   |
        (RC_W'(1) << POS_BOR)   | (RC_W'(1) << POS_POR);

    localparam logic [RC_W-1:0] RESET_WORD =
        (RC_W'(1) << POS_BOR) | (RC_W'(1) << POS_POR);

    typedef struct packed {
        logic brownout;
        logic ext_pin;
        logic sw_reset;
        logic wdt_expire;
        logic trap_conflict;
        logic bad_access;
        logic cfg_mismatch;
        logic enter_sleep;
        logic enter_idle;
        logic wdt_clear;
    } rc_events_t;

endpackage

// File: rtl/rcause_event_map.sv
module rcause_event_map
    import rcause_pkg::*;
#(
    parameter int W = RC_W
) (
    input  rc_events_t   ev,
    output logic [W-1:0] set_vec,
    output logic [W-1:0] clr_vec
);

    localparam logic [W-1:0] ONE = W'(1);

    // Bits a brown-out wipes
    localparam logic [W-1:0] BOR_CLR =
        (ONE << POS_TRAP)  | (ONE << POS_BADACC) | (ONE << POS_EXT) |
        (ONE << POS_SWRST) | (ONE << POS_WDT)    | (ONE << POS_SLEEP) |
        (ONE << POS_IDLE);

    always_comb begin
        set_vec = '0;
        set_vec[POS_TRAP]   = ev.trap_conflict;
        set_vec[POS_BADACC] = ev.bad_access;
        set_vec[POS_CFG]    = ev.cfg_mismatch;
        set_vec[POS_EXT]    = ev.ext_pin;
        set_vec[POS_SWRST]  = ev.sw_reset;
        set_vec[POS_WDT]    = ev.wdt_expire;
        set_vec[POS_SLEEP]  = ev.enter_sleep;
        set_vec[POS_IDLE]   = ev.enter_idle;
        set_vec[POS_BOR]    = ev.brownout;
    end

    always_comb begin
        clr_vec = ev.brownout ? BOR_CLR : '0;
        if (ev.enter_sleep || ev.enter_idle || ev.wdt_clear) begin
            clr_vec[POS_WDT] = 1'b1;
        end
    end

endmodule

// File: rtl/rcause_flag_cell.sv
module rcause_flag_cell #(
    parameter bit IMPL    = 1'b1,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic sw_we,
    input  logic sw_bit,
    output logic q
);

    logic nxt;

    // Priority: hardware set, hardware clear, software write, hold
    always_comb begin
        if (hw_set) begin
            nxt = 1'b1;
        end else if (hw_clr) begin
            nxt = 1'b0;
        end else if (sw_we) begin
            nxt = sw_bit;
        end else begin
            nxt = q;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q <= IMPL ? RST_VAL : 1'b0;
        end else begin
            q <= IMPL ? nxt : 1'b0;
        end
    end

endmodule

// File: rtl/rcause_reg.sv
module rcause_reg
    import rcause_pkg::*;
#(
    parameter int W = RC_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         ev_brownout,
    input  logic         ev_ext_pin,
    input  logic         ev_sw_reset,
    input  logic         ev_wdt_expire,
    input  logic         ev_trap_conflict,
    input  logic         ev_bad_access,
    input  logic         ev_cfg_mismatch,
    input  logic         ev_enter_sleep,
    input  logic         ev_enter_idle,
    input  logic         ev_wdt_clear,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data
);

    localparam logic [W-1:0] IMPL = W'(IMPL_MASK);
    localparam logic [W-1:0] RSTV = W'(RESET_WORD);

    rc_events_t   ev;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] flags;

    always_comb begin
        ev.brownout      = ev_brownout;
        ev.ext_pin       = ev_ext_pin;
        ev.sw_reset      = ev_sw_reset;
        ev.wdt_expire    = ev_wdt_expire;
        ev.trap_conflict = ev_trap_conflict;
        ev.bad_access    = ev_bad_access;
        ev.cfg_mismatch  = ev_cfg_mismatch;
        ev.enter_sleep   = ev_enter_sleep;
        ev.enter_idle    = ev_enter_idle;
        ev.wdt_clear     = ev_wdt_clear;
    end

    rcause_event_map #(.W(W)) u_map (
        .ev      (ev),
        .set_vec (set_vec),
        .clr_vec (clr_vec)
    );

    for (genvar i = 0; i < W; i++) begin : g_bit
        rcause_flag_cell #(
            .IMPL    (IMPL[i]),
            .RST_VAL (RSTV[i])
        ) u_cell (
            .clk    (clk),
            .por_n  (por_n),
            .hw_set (set_vec[i]),
            .hw_clr (clr_vec[i]),
            .sw_we  (wr_en),
            .sw_bit (wr_data[i]),
            .q      (flags[i])
        );
    end

    assign rd_data = flags;

endmodule

// File: rtl/rcause_reg_sva.sv
module rcause_reg_sva
    import rcause_pkg::*;
#(
    parameter int W = RC_W
) (
    input logic         clk,
    input logic         por_n,
    input rc_events_t   ev,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data
);

    localparam logic [W-1:0] IMPL = W'(IMPL_MASK);

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data & ~IMPL) == '0); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_en && ev == '0) |=> $stable(rd_data)); // R3

    AST_WDT_SETS: assert property (@(posedge clk) disable iff (!por_n)
        ev.wdt_expire |=> rd_data[POS_WDT]); // R2

    AST_WDT_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (ev.wdt_clear && !ev.wdt_expire) |=> !rd_data[POS_WDT]); // R5

    AST_BOR_WIPES_TRAP: assert property (@(posedge clk) disable iff (!por_n)
        (ev.brownout && !ev.trap_conflict) |=> !rd_data[POS_TRAP]); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!por_n)
        (ev.enter_sleep && ev.brownout) |=> rd_data[POS_SLEEP]); // R6

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && ev == '0) |=> rd_data == ($past(wr_data) & IMPL)); // R7

    AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[POS_CFG] && !wr_en) |=> rd_data[POS_CFG]); // R10

endmodule

bind rcause_reg rcause_reg_sva #(.W(W)) u_sva (
    .clk     (clk),
    .por_n   (por_n),
    .ev      (ev),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/rcause_reg_test.sv
module rcause_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;

    // Bench strobe mask bits
    localparam logic [9:0] E_BOR   = 10'h001;
    localparam logic [9:0] E_EXT   = 10'h002;
    localparam logic [9:0] E_SWR   = 10'h004;
    localparam logic [9:0] E_WDT   = 10'h008;
    localparam logic [9:0] E_TRAP  = 10'h010;
    localparam logic [9:0] E_BAD   = 10'h020;
    localparam logic [9:0] E_CFG   = 10'h040;
    localparam logic [9:0] E_SLP   = 10'h080;
    localparam logic [9:0] E_IDL   = 10'h100;
    localparam logic [9:0] E_WCLR  = 10'h200;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [9:0]  evm = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcause_reg uut (
        .clk              (clk),
        .por_n            (por_n),
        .ev_brownout      (evm[0]),
        .ev_ext_pin       (evm[1]),
        .ev_sw_reset      (evm[2]),
        .ev_wdt_expire    (evm[3]),
        .ev_trap_conflict (evm[4]),
        .ev_bad_access    (evm[5]),
        .ev_cfg_mismatch  (evm[6]),
        .ev_enter_sleep   (evm[7]),
        .ev_enter_idle    (evm[8]),
        .ev_wdt_clear     (evm[9]),
        .wr_en            (wr_en),
        .wr_data          (wr_data),
        .rd_data          (rd_data)
    );

    task automatic check(input string tag, input logic [15:0] exp);
        n_checks++;
        if (rd_data !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, rd_data, exp);
        end
    endtask

    // Drive for one cycle from a falling edge; result readable at the next falling edge
    task automatic apply(input logic [9:0] m, input logic we, input logic [15:0] d);
        @(negedge clk);
        evm = m; wr_en = we; wr_data = d;
        @(negedge clk);
        evm = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset;
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", 16'h0003);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 16'h0003);
    endtask

    task automatic t_write;
        apply('0, 1'b1, 16'h0000);
        check("R7 write zero", 16'h0000);
        apply('0, 1'b1, 16'hFFFF);
        check("R7 R9 write all ones", 16'hC2DF);
        apply('0, 1'b1, 16'h0000);
        apply('0, 1'b1, 16'h3D20);
        check("R9 unimplemented bits", 16'h0000);
    endtask

    task automatic t_each_set;
        logic [9:0]  m [9];
        logic [15:0] e [9];
        m[0] = E_TRAP; e[0] = 16'h8000;
        m[1] = E_BAD;  e[1] = 16'h4000;
        m[2] = E_CFG;  e[2] = 16'h0200;
        m[3] = E_EXT;  e[3] = 16'h0080;
        m[4] = E_SWR;  e[4] = 16'h0040;
        m[5] = E_WDT;  e[5] = 16'h0010;
        m[6] = E_SLP;  e[6] = 16'h0008;
        m[7] = E_IDL;  e[7] = 16'h0004;
        m[8] = E_BOR;  e[8] = 16'h0002;
        for (int i = 0; i < 9; i++) begin
            apply('0, 1'b1, 16'h0000);
            apply(m[i], 1'b0, 16'h0000);
            check("R2 event sets its flag", e[i]);
        end
        repeat (3) @(negedge clk);
        check("R3 flag holds", 16'h0002);
    endtask

    task automatic t_brownout;
        apply('0, 1'b1, 16'hC2DD);
        apply(E_BOR, 1'b0, 16'h0000);
        check("R4 R10 brown-out clears", 16'h0203);
    endtask

    task automatic t_wdt_clear;
        apply('0, 1'b1, 16'h0010);
        apply(E_SLP, 1'b0, 16'h0000);
        check("R5 sleep clears wdt", 16'h0008);
        apply('0, 1'b1, 16'h0010);
        apply(E_IDL, 1'b0, 16'h0000);
        check("R5 idle clears wdt", 16'h0004);
        apply('0, 1'b1, 16'h0010);
        apply(E_WCLR, 1'b0, 16'h0000);
        check("R5 wdt clear", 16'h0000);
    endtask

    task automatic t_cfg_sticky;
        apply('0, 1'b1, 16'h0200);
        apply(E_SLP | E_IDL | E_WCLR, 1'b0, 16'h0000);
        check("R10 cfg survives power-save", 16'h020C);
        apply(E_BOR, 1'b0, 16'h0000);
        check("R10 cfg survives brown-out", 16'h0202);
    endtask

    task automatic t_set_wins;
        apply('0, 1'b1, 16'h0000);
        apply(E_WDT | E_WCLR, 1'b0, 16'h0000);
        check("R6 wdt set beats clear", 16'h0010);
        apply('0, 1'b1, 16'h0008);
        apply(E_BOR | E_SLP, 1'b0, 16'h0000);
        check("R6 sleep set beats brown-out", 16'h000A);
    endtask

    task automatic t_hw_over_sw;
        apply('0, 1'b1, 16'h0000);
        apply(E_WDT, 1'b1, 16'h0001);
        check("R8 hw set beats write", 16'h0011);
        apply(E_BOR, 1'b1, 16'h0008);
        check("R8 hw clear beats write", 16'h0002);
    endtask

    task automatic t_por_midrun;
        apply('0, 1'b1, 16'hC2DF);
        @(negedge clk);
        por_n = 1'b0;
        #1;
        check("R1 asynchronous power-on", 16'h0003);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 R10 power-on clears cfg", 16'h0003);
    endtask

    initial begin
        t_reset();
        t_write();
        t_each_set();
        t_brownout();
        t_wdt_clear();
        t_cfg_sticky();
        t_set_wins();
        t_hw_over_sw();
        t_por_midrun();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule